// File: doc/BRIEF.md
# Strap-Mapped Register Window Decoder

This block decodes accesses from a microprocessor bus for a device whose register file holds 64 locations. Two strap inputs place the file in one of four 64-byte windows of an 8-bit address space. Two mode pins choose the bus mode and limit which registers can be reached. A compatibility input selects legacy or extended operation. In legacy operation the extended registers at 25H-3FH are switched off, and the low strap can also close the upper half of the file. For each access the decoder produces a select flag, a 6-bit register index, a read-data output enable and a write enable. All of these are registered once on the bus clock.

An access that falls outside the window, targets a register that cannot be reached, or comes with a disallowed mode-pin setting is handled exactly like an access with chip select deasserted. The read output enable stays low, so the data bus stays tri-stated, and no write enable is issued. The register contents are handled elsewhere.

Top module: `regwin_decoder`

## Requirements
- R1: While rst_n is low and in the first cycle after it, acc_sel, rd_oe, wr_en, bus_mux and reg_idx are all zero.
- R2: An access is selected only when addr[7:6] equals win_strap. win_strap[1] is the upper strap and win_strap[0] the lower, so win_strap 0..3 maps the file to 00H-3FH, 40H-7FH, 80H-BFH and C0H-FFH.
- R3: reg_idx carries addr[5:0] of a selected access and is zero when no access is selected.
- R4: In extended operation (legacy=0), hi_strap has no effect on any output.
- R5: In extended operation, mode_pin=2'b11 is disallowed, and every access is unselected.
- R6: In extended operation with mode_pin other than 2'b11, all 64 indices 00H-3FH can be read and written.
- R7: In legacy operation (legacy=1), reads and writes of indices 25H-3FH are unselected, so no write enable and no output enable result.
- R8: In legacy operation with mode_pin=2'b11, indices 20H-3FH are unselected.
- R9: In legacy operation with hi_strap=1, indices 20H-3FH are unselected.
- R10: A read is cs_n=0, rd_n=0, wr_n=1. A write is cs_n=0, wr_n=0, rd_n=1. Any other strobe combination, including both strobes low or cs_n high, is no access. rd_oe is asserted only for a selected read and wr_en only for a selected write.
- R11: bus_mux is 1 exactly when mode_pin=2'b10 (mode_pin[1] high, mode_pin[0] low). This holds in both operations.
- R12: Each output reflects the inputs sampled at the previous rising clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 8 | Bus address |
| win_strap | input | 2 | Window straps, upper strap in bit 1 |
| hi_strap | input | 1 | Low strap; in legacy operation it closes 20H-3FH |
| mode_pin | input | 2 | Mode pins, bit 1 and bit 0 |
| legacy | input | 1 | 1 selects legacy operation, 0 extended |
| acc_sel | output | 1 | Registered: a permitted access is selected |
| reg_idx | output | 6 | Registered register index of the selected access |
| rd_oe | output | 1 | Registered read-data output enable |
| wr_en | output | 1 | Registered write enable |
| bus_mux | output | 1 | Registered multiplexed-bus mode flag |

## Verification
A wrong window comparison or a wrong permission decision shows up on the very next clock. For a given address the decoder then answers when it should stay quiet, or stays quiet when it should answer: rd_oe or wr_en take the wrong level, and reg_idx goes nonzero where zero is expected. A mix-up between the two strobes shows up at once as rd_oe and wr_en swapped. The decoder holds no state beyond one register stage, so any fault appears within one cycle of the access that triggers it. A sweep over every address, strap, mode, operation and strobe pattern therefore exposes it.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned IDX_W  = 6;
  localparam int unsigned WIN_W  = ADDR_W - IDX_W;
  localparam logic [IDX_W-1:0] EXT_BASE   = 6'h25;
  localparam logic [IDX_W-1:0] UPPER_BASE = 6'h20;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_ALT   = 2'b01,
    MODE_MUX   = 2'b10,
    MODE_BAD   = 2'b11
  } mode_e;

  function automatic logic window_match(input logic [ADDR_W-1:0] a,
                                        input logic [WIN_W-1:0] w);
    return a[ADDR_W-1 -: WIN_W] == w;
  endfunction

  function automatic logic idx_allowed(input logic leg, input logic [1:0] m,
                                       input logic hs, input logic [IDX_W-1:0] i);
    if (!leg) return m != MODE_BAD;
    if (i >= EXT_BASE) return 1'b0;
    if ((m == MODE_BAD || hs) && i >= UPPER_BASE) return 1'b0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/regwin_window.sv
module regwin_window #(
  parameter int unsigned ADDR_W = regwin_pkg::ADDR_W,
  parameter int unsigned IDX_W  = regwin_pkg::IDX_W,
  localparam int unsigned WIN_W = ADDR_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIN_W-1:0]  win,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  assign hit = regwin_pkg::window_match(addr, win);
  assign idx = addr[IDX_W-1:0];
endmodule

// File: rtl/regwin_strobe.sv
module regwin_strobe (
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_req,
  output logic wr_req
);
  assign rd_req = !cs_n && !rd_n && wr_n;
  assign wr_req = !cs_n && !wr_n && rd_n;
endmodule

// File: rtl/regwin_permit.sv
module regwin_permit #(
  parameter int unsigned IDX_W = regwin_pkg::IDX_W
) (
  input  logic             legacy,
  input  logic [1:0]       mode_pin,
  input  logic             hi_strap,
  input  logic [IDX_W-1:0] idx,
  output logic             ok
);
  assign ok = regwin_pkg::idx_allowed(legacy, mode_pin, hi_strap, idx);
endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [7:0] addr,
  input  logic [1:0] win_strap,
  input  logic       hi_strap,
  input  logic [1:0] mode_pin,
  input  logic       legacy,
  output logic       acc_sel,
  output logic [5:0] reg_idx,
  output logic       rd_oe,
  output logic       wr_en,
  output logic       bus_mux
);
  import regwin_pkg::*;

  logic             win_hit;
  logic [IDX_W-1:0] win_idx;
  logic             rd_req, wr_req;
  logic             idx_ok;
  logic             go;

  regwin_window #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_win (
    .addr(addr), .win(win_strap), .hit(win_hit), .idx(win_idx)
  );

  regwin_strobe u_stb (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .rd_req(rd_req), .wr_req(wr_req)
  );

  regwin_permit #(.IDX_W(IDX_W)) u_perm (
    .legacy(legacy), .mode_pin(mode_pin), .hi_strap(hi_strap),
    .idx(win_idx), .ok(idx_ok)
  );

  assign go = win_hit && idx_ok && (rd_req || wr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_sel <= 1'b0;
      reg_idx <= '0;
      rd_oe   <= 1'b0;
      wr_en   <= 1'b0;
      bus_mux <= 1'b0;
    end else begin
      acc_sel <= go;
      reg_idx <= go ? win_idx : '0;
      rd_oe   <= go && rd_req;
      wr_en   <= go && wr_req;
      bus_mux <= (mode_pin == MODE_MUX);
    end
  end
endmodule

// File: rtl/regwin_decoder_chk.sv
module regwin_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [7:0] addr,
  input logic       legacy,
  input logic [1:0] mode_pin,
  input logic       win_hit,
  input logic       acc_sel,
  input logic [5:0] reg_idx,
  input logic       rd_oe,
  input logic       wr_en,
  input logic       bus_mux
);
  p_win_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sel |-> $past(win_hit));

  p_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sel |-> reg_idx == $past(addr[5:0]));

  p_bad_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!legacy && mode_pin == 2'b11) |-> !acc_sel);

  p_leg_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(legacy && addr[5:0] >= 6'h25) |-> !wr_en && !rd_oe);

  p_leg_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(legacy && mode_pin == 2'b11 && addr[5:0] >= 6'h20) |-> !acc_sel);

  p_oe_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> $past(!cs_n && !rd_n && wr_n));

  p_we_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(!cs_n && !wr_n && rd_n));

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_oe && wr_en));

  p_mux_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> bus_mux == $past(mode_pin == 2'b10));
endmodule

bind regwin_decoder regwin_decoder_chk u_chk (.*);

// File: tb/sim_regwin_decoder.sv
module sim_regwin_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] addr = '0;
  logic [1:0] win_strap = '0;
  logic       hi_strap = 1'b0;
  logic [1:0] mode_pin = '0;
  logic       legacy = 1'b0;
  logic       acc_sel, rd_oe, wr_en, bus_mux;
  logic [5:0] reg_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  regwin_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .win_strap(win_strap), .hi_strap(hi_strap),
    .mode_pin(mode_pin), .legacy(legacy), .acc_sel(acc_sel),
    .reg_idx(reg_idx), .rd_oe(rd_oe), .wr_en(wr_en), .bus_mux(bus_mux)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state, with an in-window read and mux mode held during reset
    addr = 8'h03; cs_n = 0; rd_n = 0; mode_pin = 2'b10;
    repeat (3) @(negedge clk);
    chk("R1", "acc_sel", acc_sel, 0);
    chk("R1", "rd_oe", rd_oe, 0);
    chk("R1", "wr_en", wr_en, 0);
    chk("R1", "bus_mux", bus_mux, 0);
    chk("R1", "reg_idx", reg_idx, 0);
    cs_n = 1; rd_n = 1; mode_pin = 2'b00;
    rst_n = 1;
    @(negedge clk);
    chk("R1", "acc_sel after release", acc_sel, 0);

    // R12: one-cycle latency
    addr = 8'h11; cs_n = 0; rd_n = 0; wr_n = 1;
    #1;
    chk("R12", "rd_oe before edge", rd_oe, 0);
    @(negedge clk);
    chk("R12", "rd_oe after edge", rd_oe, 1);
    chk("R12", "reg_idx after edge", reg_idx, 32'h11);
    cs_n = 1; rd_n = 1;
    @(negedge clk);

    // Sweep
    for (int l = 0; l < 2; l++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 2; s++)
          for (int w = 0; w < 4; w++)
            for (int op = 0; op < 4; op++)
              for (int a = 0; a < 256; a++) begin
                int off;
                bit hit, ok, rq, wq, go;
                string tag;
                legacy = l[0]; mode_pin = m[1:0]; hi_strap = s[0];
                win_strap = w[1:0]; addr = a[7:0];
                case (op)
                  0: begin cs_n = 1; rd_n = 0; wr_n = 1; end
                  1: begin cs_n = 0; rd_n = 0; wr_n = 1; end
                  2: begin cs_n = 0; rd_n = 1; wr_n = 0; end
                  default: begin cs_n = 0; rd_n = 0; wr_n = 0; end
                endcase
                @(negedge clk);
                off = a % 64;
                hit = (a / 64) == w;
                if (l == 1)
                  ok = (off < 37) && !(((m == 3) || (s == 1)) && off >= 32);
                else
                  ok = (m != 3);
                rq = (op == 1);
                wq = (op == 2);
                go = hit && ok && (rq || wq);
                if (!(rq || wq))                        tag = "R10";
                else if (!hit)                          tag = "R2";
                else if (l == 0 && m == 3)              tag = "R5";
                else if (l == 1 && off >= 37)           tag = "R7";
                else if (l == 1 && m == 3 && off >= 32) tag = "R8";
                else if (l == 1 && s == 1 && off >= 32) tag = "R9";
                else if (l == 0 && s == 1)              tag = "R4";
                else if (l == 0)                        tag = "R6";
                else                                    tag = "R2";
                chk(tag, "acc_sel", acc_sel, go);
                chk("R10", "rd_oe", rd_oe, go && rq);
                chk("R10", "wr_en", wr_en, go && wq);
                chk("R3", "reg_idx", reg_idx, go ? off : 0);
                chk("R11", "bus_mux", bus_mux, m == 2);
              end
    finish_run();
  end
endmodule